// File: doc/BRIEF.md
# Extended Control Register with Two General-Purpose Pins

This block is a 32-bit control register reached over a plain word-addressed read/write port. It drives two general-purpose pins. Each pin has a direction bit, a data bit and an edge-interrupt enable. Each pin also raises a one-cycle interrupt pulse when its synchronized input level rises, provided the pin is an input and its enable is set.

A second address holds a 32-bit interrupt cause register. Event pulses set bits in it. A read clears it according to a policy bit in the control word: with the policy set, every read clears it. With the policy clear, a read clears it only while the interrupt summary input is high or the mask-all-zero input is high.

Two command bits are self-clearing. Writing 1 to either one starts a one-cycle strobe, and both always read back as 0. The strobes come from a two-state sequencer. State `CMD_IDLE` moves to `CMD_FIRE` when a control write carries a command bit. `CMD_FIRE` stays in `CMD_FIRE` on a further command write, and otherwise returns to `CMD_IDLE`.

The pin direction bits reset only at power-on, when they load preset values from a configuration input. A software reset leaves them unchanged.

Top module: `xctl_reg`

## Requirements
- R1: After power-on reset (`por_n` low), the direction bits equal `cfg_dir` and the pin data bits equal `cfg_dout`. Every other control bit, the cause register and both command strobes are 0.
- R2: A one-cycle software reset (`srst` high) leaves both direction bits unchanged, reloads the data bits from `cfg_dout`, and clears the policy bit, the enables, bits 15 and 16, and the cause register.
- R3: At address 0, the control word has this layout: policy at bit 0, enables at bits 2 and 3, data at bits 6 and 7, directions at bits 10 and 11 (pin 0 at the lower bit of each pair), bypass at bit 15 and no-snoop disable at bit 16. All other bits, including 12 and 13, read 0, and writes to them are ignored.
- R4: `pin_oe[i]` equals direction bit i, with 1 meaning output. `pin_out[i]` equals data bit i.
- R5: Reading data bit i returns the written value while pin i is an output. While pin i is an input, it returns the `pin_in[i]` level after two clock edges of synchronization.
- R6: `gpi_pulse[i]` is high for exactly one cycle, two edges after `pin_in[i]` rises, but only while pin i is an input with its enable set. Otherwise a rising edge produces no pulse.
- R7: A control write with bit 12 (or bit 13) set makes `asd_go` (or `reload_go`) high for exactly the cycle after the write.
- R8: Bit 15 drives `spd_byps` and bit 16 drives `ns_dis`. Both are plain read/write bits.
- R9: The cause register ORs in `evt_in` every cycle, and a read at address 1 returns its current contents. Other addresses read 0.
- R10: A cause read clears the register when the policy bit is 1. When the policy bit is 0, the read clears it only if `irq_active` or `mask_zero` is high; otherwise the contents stay.
- R11: An `evt_in` bit that arrives in the same cycle as a clearing read is kept in the register after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| srst | input | 1 | Software reset, synchronous, active high |
| cfg_dir | input | 2 | Preset direction bits loaded at power-on |
| cfg_dout | input | 2 | Preset pin data bits |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Word address: 0 control, 1 cause |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pin_in | input | 2 | Pin input levels |
| pin_out | output | 2 | Pin driven values |
| pin_oe | output | 2 | Pin output enables |
| gpi_pulse | output | 2 | Per-pin edge interrupt pulses |
| evt_in | input | 32 | Cause event pulses |
| irq_active | input | 1 | Summary: an interrupt is asserted |
| mask_zero | input | 1 | Summary: the interrupt mask is all zero |
| asd_go | output | 1 | Speed-detect command strobe |
| reload_go | output | 1 | Configuration reload command strobe |
| spd_byps | output | 1 | Speed-select bypass flag |
| ns_dis | output | 1 | No-snoop disable flag |

## Verification
A new cause event and a clearing read of the cause register can fall in the same cycle. The bench provokes this by holding `evt_in` at a fresh bit during a read with the policy set. It then expects the read to return the old contents and the next read to return exactly the fresh bit. The bench also pairs a software reset with the pin direction bits, and a write of both command bits with the bypass flags, in back-to-back cycles.

// File: rtl/xctl_pkg.sv
package xctl_pkg;
    localparam int REG_W      = 32;
    localparam int BIT_POLICY = 0;
    localparam int EN_LSB     = 2;
    localparam int DATA_LSB   = 6;
    localparam int DIR_LSB    = 10;
    localparam int BIT_ASD    = 12;
    localparam int BIT_RELOAD = 13;
    localparam int BIT_BYPS   = 15;
    localparam int BIT_NSDIS  = 16;
    localparam int N_CMD      = 2;

    typedef enum logic {
        CMD_IDLE = 1'b0,
        CMD_FIRE = 1'b1
    } cmd_state_e;
endpackage

// File: rtl/xctl_pin.sv
module xctl_pin (
    input  logic clk,
    input  logic por_n,
    input  logic srst,
    input  logic wr,
    input  logic w_dir,
    input  logic w_dout,
    input  logic w_en,
    input  logic cfg_dir,
    input  logic cfg_dout,
    input  logic pin_i,
    output logic pin_o,
    output logic pin_oe_o,
    output logic rd_bit,
    output logic en_o,
    output logic dir_o,
    output logic gpi_o
);
    logic       dir_q, dout_q, en_q;
    logic [2:0] sync_q;

    // power-on-only domain
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)  dir_q <= cfg_dir;
        else if (wr) dir_q <= w_dir;
    end

    // software-reset domain
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            dout_q <= cfg_dout;
            en_q   <= 1'b0;
        end else if (srst) begin
            dout_q <= cfg_dout;
            en_q   <= 1'b0;
        end else if (wr) begin
            dout_q <= w_dout;
            en_q   <= w_en;
        end
    end

    // two synchronizer stages plus one history stage for edge detection
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], pin_i};
    end

    assign pin_o    = dout_q;
    assign pin_oe_o = dir_q;
    assign dir_o    = dir_q;
    assign en_o     = en_q;
    assign rd_bit   = dir_q ? dout_q : sync_q[1];
    assign gpi_o    = !dir_q && en_q && sync_q[1] && !sync_q[2];
endmodule

// File: rtl/xctl_cmd.sv
module xctl_cmd
    import xctl_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             srst,
    input  logic [N_CMD-1:0] fire_req,
    output logic [N_CMD-1:0] go
);
    cmd_state_e       state_q, state_nx;
    logic [N_CMD-1:0] pend_q;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            CMD_IDLE: state_nx = (|fire_req) ? CMD_FIRE : CMD_IDLE;
            CMD_FIRE: state_nx = (|fire_req) ? CMD_FIRE : CMD_IDLE;
            default:  state_nx = CMD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= CMD_IDLE;
            pend_q  <= '0;
        end else if (srst) begin
            state_q <= CMD_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_nx;
            pend_q  <= fire_req;
        end
    end

    always_comb begin
        unique case (state_q)
            CMD_FIRE: go = pend_q;
            default:  go = '0;
        endcase
    end
endmodule

// File: rtl/xctl_cause.sv
module xctl_cause #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         srst,
    input  logic [W-1:0] evt,
    input  logic         clr,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)     q <= '0;
        else if (srst)  q <= '0;
        else            q <= (clr ? '0 : q) | evt;
    end
endmodule

// File: rtl/xctl_reg.sv
module xctl_reg
    import xctl_pkg::*;
#(
    parameter int                ADDR_W     = 4,
    parameter int                N_PIN      = 2,
    parameter int                CAUSE_W    = 32,
    parameter logic [ADDR_W-1:0] CTL_ADDR   = 4'd0,
    parameter logic [ADDR_W-1:0] CAUSE_ADDR = 4'd1
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               srst,
    input  logic [N_PIN-1:0]   cfg_dir,
    input  logic [N_PIN-1:0]   cfg_dout,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [N_PIN-1:0]   pin_in,
    output logic [N_PIN-1:0]   pin_out,
    output logic [N_PIN-1:0]   pin_oe,
    output logic [N_PIN-1:0]   gpi_pulse,
    input  logic [CAUSE_W-1:0] evt_in,
    input  logic               irq_active,
    input  logic               mask_zero,
    output logic               asd_go,
    output logic               reload_go,
    output logic               spd_byps,
    output logic               ns_dis
);
    logic               ctl_wr, cause_rd, cause_clr;
    logic               policy_q, byps_q, nsdis_q;
    logic [N_PIN-1:0]   en_w, dir_w, rdb_w;
    logic [N_CMD-1:0]   fire_w, go_w;
    logic [CAUSE_W-1:0] cause_q;
    logic [REG_W-1:0]   ctl_word;

    assign ctl_wr    = bus_wr && (bus_addr == CTL_ADDR);
    assign cause_rd  = bus_rd && (bus_addr == CAUSE_ADDR);
    assign cause_clr = cause_rd && (policy_q || irq_active || mask_zero);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            policy_q <= 1'b0;
            byps_q   <= 1'b0;
            nsdis_q  <= 1'b0;
        end else if (srst) begin
            policy_q <= 1'b0;
            byps_q   <= 1'b0;
            nsdis_q  <= 1'b0;
        end else if (ctl_wr) begin
            policy_q <= bus_wdata[BIT_POLICY];
            byps_q   <= bus_wdata[BIT_BYPS];
            nsdis_q  <= bus_wdata[BIT_NSDIS];
        end
    end

    for (genvar i = 0; i < N_PIN; i++) begin : g_pin
        xctl_pin u_pin (
            .clk      (clk),
            .por_n    (por_n),
            .srst     (srst),
            .wr       (ctl_wr),
            .w_dir    (bus_wdata[DIR_LSB+i]),
            .w_dout   (bus_wdata[DATA_LSB+i]),
            .w_en     (bus_wdata[EN_LSB+i]),
            .cfg_dir  (cfg_dir[i]),
            .cfg_dout (cfg_dout[i]),
            .pin_i    (pin_in[i]),
            .pin_o    (pin_out[i]),
            .pin_oe_o (pin_oe[i]),
            .rd_bit   (rdb_w[i]),
            .en_o     (en_w[i]),
            .dir_o    (dir_w[i]),
            .gpi_o    (gpi_pulse[i])
        );
    end

    assign fire_w = {bus_wdata[BIT_RELOAD], bus_wdata[BIT_ASD]} & {N_CMD{ctl_wr}};

    xctl_cmd u_cmd (
        .clk      (clk),
        .por_n    (por_n),
        .srst     (srst),
        .fire_req (fire_w),
        .go       (go_w)
    );

    xctl_cause #(.W(CAUSE_W)) u_cause (
        .clk   (clk),
        .por_n (por_n),
        .srst  (srst),
        .evt   (evt_in),
        .clr   (cause_clr),
        .q     (cause_q)
    );

    always_comb begin
        ctl_word             = '0;
        ctl_word[BIT_POLICY] = policy_q;
        ctl_word[BIT_BYPS]   = byps_q;
        ctl_word[BIT_NSDIS]  = nsdis_q;
        for (int i = 0; i < N_PIN; i++) begin
            ctl_word[EN_LSB+i]   = en_w[i];
            ctl_word[DATA_LSB+i] = rdb_w[i];
            ctl_word[DIR_LSB+i]  = dir_w[i];
        end
    end

    always_comb begin
        if (bus_addr == CTL_ADDR)        bus_rdata = ctl_word;
        else if (bus_addr == CAUSE_ADDR) bus_rdata = REG_W'(cause_q);
        else                             bus_rdata = '0;
    end

    assign asd_go    = go_w[0];
    assign reload_go = go_w[1];
    assign spd_byps  = byps_q;
    assign ns_dis    = nsdis_q;
endmodule

// File: rtl/xctl_reg_chk.sv
module xctl_reg_chk #(
    parameter int                ADDR_W     = 4,
    parameter int                N_PIN      = 2,
    parameter int                CAUSE_W    = 32,
    parameter logic [ADDR_W-1:0] CTL_ADDR   = 4'd0,
    parameter logic [ADDR_W-1:0] CAUSE_ADDR = 4'd1
) (
    input logic               clk,
    input logic               por_n,
    input logic               srst,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic [N_PIN-1:0]   pin_oe,
    input logic [N_PIN-1:0]   gpi_pulse,
    input logic               asd_go,
    input logic               reload_go,
    input logic [CAUSE_W-1:0] evt_in,
    input logic               policy,
    input logic [CAUSE_W-1:0] cause_q
);
    logic ctl_wr, ctl_rd, cause_rd;
    assign ctl_wr   = bus_wr && (bus_addr == CTL_ADDR);
    assign ctl_rd   = bus_rd && (bus_addr == CTL_ADDR);
    assign cause_rd = bus_rd && (bus_addr == CAUSE_ADDR);

    // R2
    dir_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        (srst && !ctl_wr) |=> $stable(pin_oe));

    // R3
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        ctl_rd |-> (bus_rdata[31:17] == '0 && bus_rdata[14:12] == '0 &&
                    bus_rdata[9:8] == '0 && bus_rdata[5:4] == '0 && !bus_rdata[1]));

    // R4
    dir_view_chk: assert property (@(posedge clk) disable iff (!por_n)
        ctl_rd |-> (bus_rdata[11:10] == pin_oe));

    // R6
    gpi_input_chk: assert property (@(posedge clk) disable iff (!por_n)
        (gpi_pulse & pin_oe) == '0);

    // R6
    gpi_single_chk: assert property (@(posedge clk) disable iff (!por_n)
        (|gpi_pulse) |=> ((gpi_pulse & $past(gpi_pulse)) == '0));

    // R7
    asd_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
        asd_go |-> $past(ctl_wr && bus_wdata[12]));

    // R7
    reload_fire_chk: assert property (@(posedge clk) disable iff (!por_n)
        (ctl_wr && bus_wdata[13] && !srst) |=> reload_go);

    // R10
    policy_clr_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cause_rd && policy && !srst) |=> (cause_q == $past(evt_in)));
endmodule

bind xctl_reg xctl_reg_chk #(
    .ADDR_W(ADDR_W), .N_PIN(N_PIN), .CAUSE_W(CAUSE_W),
    .CTL_ADDR(CTL_ADDR), .CAUSE_ADDR(CAUSE_ADDR)
) u_chk (
    .clk(clk), .por_n(por_n), .srst(srst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_oe(pin_oe), .gpi_pulse(gpi_pulse), .asd_go(asd_go), .reload_go(reload_go),
    .evt_in(evt_in), .policy(policy_q), .cause_q(cause_q)
);

// File: tb/sim_xctl_reg.sv
module sim_xctl_reg;
    logic        clk = 1'b0;
    logic        por_n, srst;
    logic [1:0]  cfg_dir, cfg_dout, pin_in, pin_out, pin_oe, gpi_pulse;
    logic        bus_wr, bus_rd;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata, evt_in;
    logic        irq_active, mask_zero, asd_go, reload_go, spd_byps, ns_dis;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    xctl_reg u0 (
        .clk(clk), .por_n(por_n), .srst(srst), .cfg_dir(cfg_dir), .cfg_dout(cfg_dout),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .gpi_pulse(gpi_pulse), .evt_in(evt_in), .irq_active(irq_active),
        .mask_zero(mask_zero), .asd_go(asd_go), .reload_go(reload_go),
        .spd_byps(spd_byps), .ns_dis(ns_dis)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item for every read cycle
    always @(negedge clk) begin
        if (bus_rd) begin
            if (exp_q.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
            else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = a;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic evt(input logic [31:0] e);
        evt_in = e;
        tick();
        evt_in = '0;
    endtask

    initial begin
        logic [1:0] seen;
        por_n = 1'b0; srst = 1'b0; cfg_dir = 2'b10; cfg_dout = 2'b01;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        pin_in = 2'b00; evt_in = '0; irq_active = 1'b0; mask_zero = 1'b0;
        repeat (3) tick();
        por_n = 1'b1;
        tick();

        // R1 power-on presets
        chk("R1 pin_oe preset", 32'(pin_oe), 32'h2);
        chk("R4 pin_out preset", 32'(pin_out), 32'h1);
        chk("R1 strobes idle", {30'd0, reload_go, asd_go}, 32'h0);
        rd(4'd0, 32'h0000_0800, "R1 ctl after power-on");
        rd(4'd1, 32'h0, "R1 cause after power-on");
        rd(4'd5, 32'h0, "R9 unmapped address reads 0");

        // R3 R7 R8 write all ones
        wr(4'd0, 32'hFFFF_FFFF);
        chk("R7 both strobes fire", {30'd0, reload_go, asd_go}, 32'h3);
        chk("R8 flags", {30'd0, ns_dis, spd_byps}, 32'h3);
        chk("R4 all outputs", {28'd0, pin_oe, pin_out}, 32'hF);
        tick();
        chk("R7 strobes one cycle", {30'd0, reload_go, asd_go}, 32'h0);
        rd(4'd0, 32'h0001_8CCD, "R3 layout after all-ones write");

        // R2 software reset
        srst = 1'b1;
        tick();
        srst = 1'b0;
        chk("R2 dir kept", 32'(pin_oe), 32'h3);
        chk("R2 data from cfg", 32'(pin_out), 32'h1);
        chk("R2 flags cleared", {30'd0, ns_dis, spd_byps}, 32'h0);
        rd(4'd0, 32'h0000_0C40, "R2 ctl after software reset");

        // R6 R5 input pin 0 enabled
        wr(4'd0, 32'h0000_0004);
        chk("R4 inputs", 32'(pin_oe), 32'h0);
        pin_in = 2'b01;
        tick();
        chk("R6 no pulse after one edge", 32'(gpi_pulse), 32'h0);
        tick();
        chk("R6 pulse pin0", 32'(gpi_pulse), 32'h1);
        rd(4'd0, 32'h0000_0044, "R5 live input level");
        chk("R6 pulse ends", 32'(gpi_pulse), 32'h0);

        // R6 disabled pin 1 gives no pulse
        pin_in = 2'b11;
        seen = '0;
        for (int k = 0; k < 4; k++) begin tick(); seen |= gpi_pulse; end
        chk("R6 disabled pin silent", 32'(seen), 32'h0);

        // R6 R5 output-mode pin 0 ignores its input
        wr(4'd0, 32'h0000_0404);
        pin_in = 2'b10;
        repeat (3) tick();
        pin_in = 2'b11;
        seen = '0;
        for (int k = 0; k < 4; k++) begin tick(); seen |= gpi_pulse; end
        chk("R6 output pin silent", 32'(seen), 32'h0);
        chk("R4 pin0 drives written 0", 32'(pin_out[0]), 32'h0);
        rd(4'd0, 32'h0000_0484, "R5 output value not pin level");

        // R9 R10 cause, conditional policy
        evt(32'h0000_0008);
        rd(4'd1, 32'h8, "R9 cause set");
        rd(4'd1, 32'h8, "R10 no clear without condition");
        irq_active = 1'b1;
        rd(4'd1, 32'h8, "R10 read with irq_active");
        irq_active = 1'b0;
        rd(4'd1, 32'h0, "R10 cleared by irq_active");
        evt(32'h0000_0030);
        mask_zero = 1'b1;
        rd(4'd1, 32'h30, "R10 read with mask_zero");
        mask_zero = 1'b0;
        rd(4'd1, 32'h0, "R10 cleared by mask_zero");
        evt(32'h0000_0001);
        evt(32'h0000_0100);
        rd(4'd1, 32'h101, "R9 accumulate");

        // R10 R11 unconditional policy with collision
        wr(4'd0, 32'h0000_0405);
        evt_in = 32'h0000_0004;
        rd(4'd1, 32'h101, "R11 read during event");
        evt_in = '0;
        rd(4'd1, 32'h4, "R11 event kept across clear");
        rd(4'd1, 32'h0, "R10 policy always clears");

        chk("scoreboard drained", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule